// File: doc/BRIEF.md
# Signed Shift-and-Add Array Multiplier

This block multiplies a signed data word by a signed filter coefficient, both in two's complement, and returns a 40-bit signed product. It is meant as the tap multiplier of a filter datapath. It builds one partial product for each coefficient bit. Each partial product places the data word at that bit's offset inside a fixed 40-bit operand, with zeros below the word and copies of its sign bit above. A linear chain of 40-bit ripple-carry adders sums the partial products. The partial product of the coefficient's top bit carries negative weight, so the chain subtracts it: the last adder takes that partial product inverted and has its carry-in set to 1.

The data width and the coefficient width are parameters, 16 bits each by default, and their sum must not exceed 40. A parameter selects an optional output register. That register captures the product on each rising clock edge and has a synchronous active-high reset. With the register off, the product follows the inputs through logic alone.

Top module: `sam_mult`

## Requirements
- R1: For every input pair, `product` equals the two's-complement product of `dataIn` and `coefIn`, sign-extended to 40 bits.
- R2: A coefficient of zero gives a product of zero for any data word.
- R3: A data word of zero gives a product of zero for any coefficient.
- R4: The most negative data (-32768) times the most negative coefficient (-32768) gives +2^30 (40'h0040000000).
- R5: A negative coefficient, which has bit COEF_W-1 set, is weighted correctly through the subtraction. For example, 1 × -1 gives all forty bits at 1, and -1 × -1 gives +1.
- R6: Partial product i has zeros in bits below i. When coefficient bit i is 0 it is all zeros. When bit i is 1, bit 39 equals the data sign bit.
- R7: With REG_OUT=1, `product` shows the result of the inputs that were present at the previous rising edge. A change of input between edges does not reach `product` until the next edge.
- R8: With REG_OUT=1, a rising edge with `rst` high sets `product` to zero, whatever the inputs are.
- R9: With REG_OUT=0, `product` follows the inputs with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | DATA_W | Signed data word |
| coefIn | input | COEF_W | Signed coefficient |
| product | output | 40 | Signed product |

## Verification
On every clock edge outside reset, the assertions compare the output of the adder chain with a behavioural signed multiply. They also check the zero-operand cases, the zero-fill and sign-fill of each partial product, the one-cycle latency of the output register and the clear on reset. The bench scenarios are what show the behaviour as seen at the ports. These are the corner-value results from a fixed table, random operand pairs compared on both the registered and the combinational variant, an input change that the output must not show before the next edge, and a reset held while the operands are nonzero.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int ACC_W = 40;

  typedef struct packed {
    logic capture;
    logic clear;
  } sam_strobe_t;
endpackage

// File: rtl/sam_rca.sv
module sam_rca #(
  parameter int W = 40
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         carryIn,
  output logic [W-1:0] sum
);
  logic [W:0] carry;
  assign carry[0] = carryIn;

  for (genvar b = 0; b < W; b++) begin : g_fa
    assign sum[b]     = addA[b] ^ addB[b] ^ carry[b];
    assign carry[b+1] = (addA[b] & addB[b]) | (carry[b] & (addA[b] ^ addB[b]));
  end

  // The carry out of the top bit is dropped: arithmetic is modulo 2^W.
  logic unusedCarry;
  assign unusedCarry = carry[W];
endmodule

// File: rtl/sam_ppgen.sv
module sam_ppgen
  import sam_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [COEF_W-1:0]       coefIn,
  output logic [COEF_W-1:0][ACC_W-1:0] partial
);
  // Each row puts the data word at offset i: zeros below, sign copies above.
  for (genvar i = 0; i < COEF_W; i++) begin : g_row
    for (genvar b = 0; b < ACC_W; b++) begin : g_bit
      if (b < i) begin : g_low
        assign partial[i][b] = 1'b0;
      end else if (b < i + DATA_W) begin : g_data
        assign partial[i][b] = coefIn[i] & dataIn[b-i];
      end else begin : g_sign
        assign partial[i][b] = coefIn[i] & dataIn[DATA_W-1];
      end
    end

    // R6
    pp_sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
      partial[i][ACC_W-1] == (coefIn[i] & dataIn[DATA_W-1]));

    // R6
    pp_zero_row_chk: assert property (@(posedge clk) disable iff (rst)
      !coefIn[i] |-> partial[i] == '0);

    if (i > 0) begin : g_lowchk
      // R6
      pp_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        partial[i][i-1:0] == '0);
    end
  end
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        rst,
  output sam_strobe_t strobes
);
  always_comb begin
    strobes.capture = REG_OUT && !rst;
    strobes.clear   = REG_OUT && rst;
  end
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import sam_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  sam_strobe_t       strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [COEF_W-1:0] coefIn,
  output logic [ACC_W-1:0]  product
);
  localparam int LAST = COEF_W - 1;

  logic [COEF_W-1:0][ACC_W-1:0] partial;
  logic [COEF_W-1:0][ACC_W-1:0] runSum;
  logic [ACC_W-1:0] combProd;

  sam_ppgen #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_ppgen (
    .clk(clk), .rst(rst), .dataIn(dataIn), .coefIn(coefIn), .partial(partial)
  );

  assign runSum[0] = partial[0];

  // Linear chain; the top row has negative weight and is subtracted.
  for (genvar i = 1; i < COEF_W; i++) begin : g_chain
    logic [ACC_W-1:0] addend;
    logic             cin;
    if (i == LAST) begin : g_sub
      assign addend = ~partial[i];
      assign cin    = 1'b1;
    end else begin : g_add
      assign addend = partial[i];
      assign cin    = 1'b0;
    end
    sam_rca #(.W(ACC_W)) u_rca (
      .addA(runSum[i-1]), .addB(addend), .carryIn(cin), .sum(runSum[i])
    );
  end

  assign combProd = runSum[LAST];

  logic signed [ACC_W-1:0] refProd;
  assign refProd = $signed(dataIn) * $signed(coefIn);

  // R1
  mult_result_chk: assert property (@(posedge clk) disable iff (rst)
    combProd == refProd);
  // R2
  zero_coef_chk: assert property (@(posedge clk) disable iff (rst)
    coefIn == '0 |-> combProd == '0);
  // R3
  zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    dataIn == '0 |-> combProd == '0);

  if (REG_OUT) begin : g_reg
    logic [ACC_W-1:0] prodQ;
    always_ff @(posedge clk) begin
      if (strobes.clear)        prodQ <= '0;
      else if (strobes.capture) prodQ <= combProd;
    end
    assign product = prodQ;

    // R7
    reg_latency_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> product == $past(refProd));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> product == '0);
  end else begin : g_comb
    assign product = combProd;
    logic unusedStrobe;
    assign unusedStrobe = strobes.capture ^ strobes.clear;
  end
endmodule

// File: rtl/sam_mult.sv
module sam_mult
  import sam_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [COEF_W-1:0] coefIn,
  output logic [ACC_W-1:0]  product
);
  sam_strobe_t strobes;

  sam_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (.rst(rst), .strobes(strobes));

  sam_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .dataIn(dataIn), .coefIn(coefIn), .product(product)
  );
endmodule

// File: tb/sam_mult_tb.sv
module sam_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 60;

  typedef struct packed {
    logic [15:0] d;
    logic [15:0] c;
    logic [39:0] e;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{16'sd3,      16'sd5,      40'sd15},          // R1
    '{-16'sd3,     16'sd5,      -40'sd15},         // R1
    '{16'sd3,      -16'sd5,     -40'sd15},         // R5
    '{-16'sd3,     -16'sd5,     40'sd15},          // R5
    '{16'sd0,      -16'sd32768, 40'sd0},           // R3
    '{-16'sd32768, 16'sd0,      40'sd0},           // R2
    '{-16'sd32768, -16'sd32768, 40'sd1073741824},  // R4
    '{16'sd32767,  16'sd32767,  40'sd1073676289},  // R1
    '{-16'sd32768, 16'sd32767,  -40'sd1073709056}, // R1
    '{16'sd1,      -16'sd1,     -40'sd1},          // R5
    '{-16'sd1,     -16'sd1,     40'sd1},           // R5
    '{16'sd256,    -16'sd2,     -40'sd512}         // R5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] coefIn = '0;
  logic [39:0] prodReg, prodComb;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sam_mult #(.DATA_W(16), .COEF_W(16), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .coefIn(coefIn), .product(prodReg)
  );
  sam_mult #(.DATA_W(16), .COEF_W(16), .REG_OUT(1'b0)) u_dutComb (
    .clk(clk), .rst(rst), .dataIn(dataIn), .coefIn(coefIn), .product(prodComb)
  );

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] refMul(logic [15:0] d, logic [15:0] c);
    logic signed [39:0] r;
    r = $signed(d) * $signed(c);
    return r;
  endfunction

  task automatic runPair(string req, logic [15:0] d, logic [15:0] c, logic [39:0] e);
    @(negedge clk);
    dataIn = d;
    coefIn = c;
    #1;
    check({req, " comb R9"}, prodComb, e);
    @(negedge clk);
    check({req, " reg R7"}, prodReg, e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state of the registered output
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset state", prodReg, 40'd0);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < 12; k++) begin
      runPair("R1 table", VECS[k].d, VECS[k].c, VECS[k].e);
    end

    // R2 / R3 with random other operand
    runPair("R2 zero coef", 16'h8001, 16'h0000, 40'd0);
    runPair("R3 zero data", 16'h0000, 16'h7ffe, 40'd0);
    // R4 explicit
    runPair("R4 min*min", 16'h8000, 16'h8000, 40'h0040000000);

    // Random pairs: R1
    for (int k = 0; k < NRAND; k++) begin
      logic [15:0] d, c;
      d = 16'($urandom);
      c = 16'($urandom);
      runPair("R1 random", d, c, refMul(d, c));
    end

    // R7: change input between edges, registered output holds
    runPair("R7 setup", 16'd7, 16'd9, 40'd63);
    @(negedge clk);
    dataIn = 16'd100;
    coefIn = -16'sd3;
    #1;
    check("R7 hold before edge", prodReg, 40'd63);
    check("R9 immediate", prodComb, -40'sd300);
    @(negedge clk);
    check("R7 after edge", prodReg, -40'sd300);

    // R8: reset with nonzero operands
    @(negedge clk);
    rst = 1'b1;
    dataIn = 16'h1234;
    coefIn = 16'h0567;
    @(negedge clk);
    check("R8 reset clears", prodReg, 40'd0);
    check("R9 during reset", prodComb, refMul(16'h1234, 16'h0567));
    rst = 1'b0;
    @(negedge clk);
    check("R8 release", prodReg, refMul(16'h1234, 16'h0567));

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule